// File: doc/BRIEF.md
# Serial Pixel Counter Decoder and Coarse/Fine Combiner

This block sits at the end of a daisy chain of per-pixel 10-bit counters that are built as XNOR linear feedback shift registers. It collects the serial bit stream from the chain, assembles one 10-bit counter state per pixel, and turns each state into the plain binary count it stands for. The conversion is a sequential search: a local register starts at the all-zero state and steps through the same feedback sequence once per clock until it equals the received state. The number of steps taken is the count.

A capture produces two readouts. The first readout carries the coarse count, which is the number of self-resets during integration. The second readout carries the fine count, which is the ramp conversion of the residue. A phase flag says which readout the current bits belong to. Decoded coarse counts are held in an internal store indexed by pixel position. When the fine count for the same position has been decoded, the block emits a 20-bit linear value with the coarse count above the fine count, together with the pixel index and a one-cycle valid strobe.

The source must leave at least 2^WORD_W cycles between the completion of one word and the completion of the next, so that each search can finish. A new word that completes earlier restarts the search, and the previous result is lost.

Top module: `pix_lfsr_combiner`

## Requirements
- R1: While rstN is low, and right after it is released, pixValid, pixErr, pixIndex and pixValue are all zero.
- R2: A word is formed from exactly WORD_W bits sampled on cycles with bitValid high, and the first bit is the most significant. The stage-10 bit, bit 9, leads. Cycles with bitValid low are ignored whatever serData holds.
- R3: The decoded count of a word is the number n of steps that take the all-zero state to that word. One step is next = {s[8:0], ~(s[6] ^ s[9])}, using feedback taps at stages 7 and 10 (bits 6 and 9).
- R4: The all-ones word is never reached by the sequence. It decodes to 1023 and raises the error flag. pixErr is high when either the coarse word or the fine word of a pixel was flagged.
- R5: A word completed while finePhase is low (coarse) produces no output pulse. Its decoded count is stored at its pixel index.
- R6: A word completed while finePhase is high (fine) produces exactly one pixValid pulse. pixValue[19:10] is the stored coarse count for that index, pixValue[9:0] is the fine count, and pixIndex is the word's position within its readout.
- R7: Any change of finePhase discards a partially received word and restarts both the bit position and the pixel index at zero.
- R8: For a word whose count is n, pixValid rises n+1 clock edges after the edge that samples the word's last bit.
- R9: pixValid is high for one cycle per fine word.
- R10: The pixel index wraps from NUM_PIX-1 to 0 within a readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial counter bit from the pixel chain |
| bitValid | input | 1 | serData carries a bit this cycle |
| finePhase | input | 1 | 0: coarse readout, 1: fine readout |
| pixValid | output | 1 | One-cycle strobe for a combined pixel value |
| pixIndex | output | $clog2(NUM_PIX) | Pixel position of the value |
| pixValue | output | 2*WORD_W | Coarse count in the upper half, fine count in the lower half |
| pixErr | output | 1 | The coarse or fine word was the unreachable state |

## Verification
The hardest situations to reach are the extremes of the search and the index bookkeeping across readouts. These are a word that matches on the very first compare, a word that needs the full 1022 steps, the unreachable all-ones word, and a fine readout that wraps its index or reuses coarse entries left over from an earlier frame. The bench drives these directly with encoded states it computes itself. A short coarse readout ends in a dangling partial word and is followed by a fine readout longer than the cluster, so that restart, wrap and stale-store reuse all show up in the output values. Bit gaps filled with garbage data are mixed into the stream, and one word is timed from its last bit to its output strobe.

// File: rtl/pix_lfsr_combiner_pkg.sv
package pix_lfsr_combiner_pkg;
  typedef struct packed {
    logic loadWord;
    logic step;
    logic finish;
    logic wordFine;
  } ctrlStrobes_t;
endpackage

// File: rtl/pix_lfsr_combiner_ctrl.sv
module pix_lfsr_combiner_ctrl
  import pix_lfsr_combiner_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int NUM_PIX = 256,
  localparam int IDX_W  = $clog2(NUM_PIX),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             finePhase,
  input  logic             match,
  input  logic             atLast,
  output ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] wordIdx
);
  logic             phaseQ;
  logic             phaseChg;
  logic [BIT_W-1:0] bitCnt, effBit;
  logic [IDX_W-1:0] idxCnt, effIdx, idxLat;
  logic             fineLat;
  logic             busy;
  logic             wordDone;

  assign phaseChg = finePhase != phaseQ;
  assign effBit   = phaseChg ? '0 : bitCnt;
  assign effIdx   = phaseChg ? '0 : idxCnt;
  assign wordDone = bitValid && (effBit == BIT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      bitCnt  <= '0;
      idxCnt  <= '0;
      idxLat  <= '0;
      fineLat <= 1'b0;
      busy    <= 1'b0;
    end else begin
      phaseQ <= finePhase;
      if (bitValid) bitCnt <= wordDone ? '0 : effBit + BIT_W'(1);
      else          bitCnt <= effBit;
      if (wordDone) begin
        idxCnt  <= (effIdx == IDX_W'(NUM_PIX - 1)) ? '0 : effIdx + IDX_W'(1);
        idxLat  <= effIdx;
        fineLat <= finePhase;
        busy    <= 1'b1;
      end else begin
        idxCnt <= effIdx;
        if (strobes.finish) busy <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.loadWord = wordDone;
    strobes.step     = busy && !match && !atLast;
    strobes.finish   = busy && (match || atLast);
    strobes.wordFine = fineLat;
  end
  assign wordIdx = idxLat;

  // R7: a phase change restarts pixel numbering
  a_r7_index_restart: assert property (@(posedge clk) disable iff (!rstN)
    (finePhase != phaseQ) |=> (idxCnt == '0));
endmodule

// File: rtl/pix_lfsr_combiner_dpath.sv
module pix_lfsr_combiner_dpath
  import pix_lfsr_combiner_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int NUM_PIX = 256,
  parameter int TAP_A   = 7,
  parameter int TAP_B   = 10,
  localparam int IDX_W  = $clog2(NUM_PIX),
  localparam int OUT_W  = 2 * WORD_W,
  localparam logic [WORD_W-1:0] CNT_MAX = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             bitValid,
  input  ctrlStrobes_t     strobes,
  input  logic [IDX_W-1:0] wordIdx,
  output logic             match,
  output logic             atLast,
  output logic             pixValid,
  output logic [IDX_W-1:0] pixIndex,
  output logic [OUT_W-1:0] pixValue,
  output logic             pixErr
);
  logic [WORD_W-2:0] shReg;
  logic [WORD_W-1:0] target, refState, stepCnt, refNext, result;
  logic              feedback;
  logic [WORD_W:0]   coarseMem [NUM_PIX];
  logic [WORD_W:0]   coarseRd;

  assign feedback = ~(refState[TAP_A-1] ^ refState[TAP_B-1]);
  assign refNext  = {refState[WORD_W-2:0], feedback};
  assign match    = refState == target;
  assign atLast   = stepCnt == CNT_MAX - WORD_W'(1);
  assign result   = match ? stepCnt : CNT_MAX;
  assign coarseRd = coarseMem[wordIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      target   <= '0;
      refState <= '0;
      stepCnt  <= '0;
      pixValid <= 1'b0;
      pixIndex <= '0;
      pixValue <= '0;
      pixErr   <= 1'b0;
    end else begin
      if (bitValid) shReg <= {shReg[WORD_W-3:0], serData};
      if (strobes.loadWord) begin
        target   <= {shReg, serData};
        refState <= '0;
        stepCnt  <= '0;
      end else if (strobes.step) begin
        refState <= refNext;
        stepCnt  <= stepCnt + WORD_W'(1);
      end
      pixValid <= strobes.finish && strobes.wordFine;
      if (strobes.finish && strobes.wordFine) begin
        pixIndex <= wordIdx;
        pixValue <= {coarseRd[WORD_W-1:0], result};
        pixErr   <= coarseRd[WORD_W] | !match;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.finish && !strobes.wordFine) coarseMem[wordIdx] <= {!match, result};
  end

  // R4: search never runs past the last reachable state
  a_r4_search_bound: assert property (@(posedge clk) disable iff (!rstN)
    stepCnt <= CNT_MAX - WORD_W'(1));
  // R5: coarse results stay inside the block
  a_r5_coarse_silent: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && !strobes.wordFine) |=> !pixValid);
  // R6: a finished fine word is emitted with its index
  a_r6_fine_emit: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && strobes.wordFine) |=> (pixValid && pixIndex == $past(wordIdx)));
  // R9: output strobe lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> !pixValid);
endmodule

// File: rtl/pix_lfsr_combiner.sv
module pix_lfsr_combiner
  import pix_lfsr_combiner_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int NUM_PIX = 256,
  parameter int TAP_A   = 7,
  parameter int TAP_B   = 10,
  localparam int IDX_W  = $clog2(NUM_PIX),
  localparam int OUT_W  = 2 * WORD_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serData,
  input  logic             bitValid,
  input  logic             finePhase,
  output logic             pixValid,
  output logic [IDX_W-1:0] pixIndex,
  output logic [OUT_W-1:0] pixValue,
  output logic             pixErr
);
  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] wordIdx;
  logic             match, atLast;

  pix_lfsr_combiner_ctrl #(.WORD_W(WORD_W), .NUM_PIX(NUM_PIX)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .finePhase(finePhase),
    .match(match), .atLast(atLast), .strobes(strobes), .wordIdx(wordIdx)
  );

  pix_lfsr_combiner_dpath #(.WORD_W(WORD_W), .NUM_PIX(NUM_PIX),
                            .TAP_A(TAP_A), .TAP_B(TAP_B)) dpath_i (
    .clk(clk), .rstN(rstN), .serData(serData), .bitValid(bitValid),
    .strobes(strobes), .wordIdx(wordIdx), .match(match), .atLast(atLast),
    .pixValid(pixValid), .pixIndex(pixIndex), .pixValue(pixValue), .pixErr(pixErr)
  );
endmodule

// File: tb/pix_lfsr_combiner_tb_top.sv
module pix_lfsr_combiner_tb_top;
  localparam int WW = 10;
  localparam int NP = 8;
  localparam int IW = $clog2(NP);
  localparam int GAP = 1030;

  typedef struct packed {
    logic [2*WW-1:0] val;
    logic [IW-1:0]   idx;
    logic            err;
  } exp_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, serData, bitValid, finePhase;
  logic pixValid, pixErr;
  logic [IW-1:0] pixIndex;
  logic [2*WW-1:0] pixValue;

  exp_t  expQ[$];
  string tagQ[$];
  int nTests = 0, nFail = 0, outSeen = 0;
  logic [WW-1:0] coarseRec [NP];
  logic          coarseErr [NP];

  pix_lfsr_combiner #(.WORD_W(WW), .NUM_PIX(NP)) dut_i (
    .clk(clk), .rstN(rstN), .serData(serData), .bitValid(bitValid),
    .finePhase(finePhase), .pixValid(pixValid), .pixIndex(pixIndex),
    .pixValue(pixValue), .pixErr(pixErr)
  );

  function automatic logic [WW-1:0] lfsrOf(int n);
    logic [WW-1:0] s = '0;
    for (int i = 0; i < n; i++) s = {s[WW-2:0], ~(s[6] ^ s[9])};
    return s;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: compares every output pulse with the scoreboard
  always @(negedge clk) begin : mon
    exp_t  e;
    string t;
    if (rstN && pixValid) begin
      outSeen++;
      if (expQ.size() == 0) check(1'b0, "R5", "unexpected pulse", 32'(pixValue), 32'h0);
      else begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(pixValue == e.val, t, "value", 32'(pixValue), 32'(e.val));
        check(pixIndex == e.idx, t, "index", 32'(pixIndex), 32'(e.idx));
        check(pixErr == e.err, t, "err", 32'(pixErr), 32'(e.err));
      end
    end
  end

  task automatic sendWord(logic [WW-1:0] w, bit gaps);
    for (int i = WW - 1; i >= 0; i--) begin
      @(negedge clk); bitValid = 1'b1; serData = w[i];
      if (gaps && (i % 3 == 0)) begin
        @(negedge clk); bitValid = 1'b0; serData = ~w[i];   // R2: ignored bit slot
      end
    end
    @(negedge clk); bitValid = 1'b0; serData = 1'b0;
  endtask

  function automatic logic [WW-1:0] enc(int n);
    return (n < 0) ? '1 : lfsrOf(n);
  endfunction

  task automatic sendCoarse(int n, int idx, bit gaps);
    coarseRec[idx] = (n < 0) ? '1 : WW'(n);
    coarseErr[idx] = (n < 0);
    sendWord(enc(n), gaps);
    repeat (GAP) @(negedge clk);
  endtask

  task automatic pushFine(int n, int idx, string tag);
    exp_t e;
    e.val = {coarseRec[idx], (n < 0) ? {WW{1'b1}} : WW'(n)};
    e.idx = IW'(idx);
    e.err = coarseErr[idx] | (n < 0);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic sendFine(int n, int idx, bit gaps, string tag);
    pushFine(n, idx, tag);
    sendWord(enc(n), gaps);
    repeat (GAP) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int cA[NP] = '{0, 1, 5, 100, 512, 1021, 1022, -1};
    int fA[NP] = '{3, 0, 1022, 7, 1, 200, -1, 44};
    int c2[5]  = '{9, 300, 2, 0, 77};
    int f2[NP + 1] = '{5, 11, 640, 1, 0, 33, 1022, 18, 250};
    int lat;
    rstN = 1'b0; bitValid = 1'b0; finePhase = 1'b0; serData = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pixValid == 1'b0, "R1", "pixValid", 32'(pixValid), 0);
    check(pixErr == 1'b0, "R1", "pixErr", 32'(pixErr), 0);
    check(pixIndex == '0, "R1", "pixIndex", 32'(pixIndex), 0);
    check(pixValue == '0, "R1", "pixValue", 32'(pixValue), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(pixValid == 1'b0, "R1", "pixValid after release", 32'(pixValid), 0);

    // frame 1 coarse: extremes of the search, lock-up word (R4), gaps (R2)
    for (int i = 0; i < NP; i++) sendCoarse(cA[i], i, i % 2);
    check(outSeen == 0, "R5", "pulses during coarse readout", 32'(outSeen), 0);

    // frame 1 fine (R2 R3 R6, lock-up in fine for R4)
    @(negedge clk); finePhase = 1'b1;
    for (int i = 0; i < NP; i++)
      sendFine(fA[i], i, (i % 2) == 0, (fA[i] < 0 || cA[i] < 0) ? "R4" : "R2 R3 R6");
    check(expQ.size() == 0, "R6", "missing outputs frame 1", 32'(expQ.size()), 0);

    // frame 2 coarse: short readout ending with a partial word (R7)
    @(negedge clk); finePhase = 1'b0;
    for (int i = 0; i < 5; i++) sendCoarse(c2[i], i, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bitValid = 1'b1; serData = i[0];
    end
    @(negedge clk); bitValid = 1'b0;
    check(outSeen == NP, "R5", "pulses during coarse readout 2", 32'(outSeen), 32'(NP));

    // frame 2 fine: index restart (R7), latency (R8), stale entries, wrap (R10)
    @(negedge clk); finePhase = 1'b1;
    pushFine(f2[0], 0, "R7");
    sendWord(enc(f2[0]), 1'b0);
    lat = 0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
    end while (!pixValid && lat < 2000);
    check(lat == f2[0] + 1, "R8", "edges to pixValid", 32'(lat), 32'(f2[0] + 1));
    repeat (GAP) @(negedge clk);
    for (int i = 1; i < NP; i++) sendFine(f2[i], i, 1'b1, "R7");
    sendFine(f2[NP], 0, 1'b0, "R10");
    check(expQ.size() == 0, "R6", "missing outputs frame 2", 32'(expQ.size()), 0);
    check(outSeen == 2 * NP + 1, "R9", "pulse count", 32'(outSeen), 32'(2 * NP + 1));

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule